// File: doc/BRIEF.md
# Tagged Geometric-History Direction Predictor

This block predicts whether a conditional branch is taken. A small 2-bit counter table, indexed only by the branch address, is the fallback. Three partially tagged tables sit above it, and each one correlates the branch address with a longer slice of the global outcome history. The slice lengths grow geometrically: 5, 15 and 44 outcomes. A lookup presents a PC. The same cycle, the block returns a taken/not-taken prediction together with the identity of the table that supplied it, the identity of the alternate table, and whether the alternate's answer was used.

A lookup strobe captures the lookup's indices, tags and provider details in a one-branch holding register. When the branch resolves, the caller signals the actual outcome. The block then trains the counters and useful bits, allocates a fresh entry in a longer-history table if the prediction was wrong, and shifts the global and path history registers. The intended use is one lookup, then its resolution, with no second branch in flight.

Top module: `geo_dir_pred`

## Requirements
- R1: After reset, every tagged entry is empty, every base counter holds 1 (weakly not-taken) and both histories are zero, so every lookup returns pred_taken=0 with pred_src=0.
- R2: The base table holds 2-bit counters indexed by pc[7:0] and predicts taken when the counter is 2 or more. It supplies the prediction when no tagged table hits. At resolution, its counter saturates toward the outcome only when it was the provider.
- R3: Define fold(h,L,W) as bit i of h, for each i<L, XORed into bit i mod W. Table t uses history length L = 5, 15 or 44 for t = 1, 2, 3.
  - Its 6-bit index is pc[5:0] ^ pc[11:6] ^ fold(ghist,L,6) ^ fold(phist,min(L,16),6).
  - Its 8-bit tag is pc[15:8] ^ fold(ghist,L,8) ^ (fold(ghist,L,7)<<1).
  - A table hits when the indexed entry is filled and its stored tag equals the computed tag.
- R4: The highest-numbered hitting table is the provider, and pred_src reports its number (0 means the base table). The next-highest hitting table is the alternate, reported on pred_alt, with 0 meaning the base table.
- R5: A provider entry counts as newly allocated when its useful counter is 0 and its 3-bit counter is 3 or 4. In that case the alternate's prediction is used and pred_alt_used=1. Otherwise the provider's counter bit 2 is the prediction.
- R6: At resolution, the provider's 3-bit counter moves one step toward the outcome and saturates at 0 and 7.
- R7: When the provider's and alternate's predictions differ, the provider's 2-bit useful counter saturates up if the provider was right and down if it was wrong. Otherwise it is left unchanged.
- R8: On a wrong final prediction, the lowest-numbered table above the provider whose candidate entry has useful counter 0 receives a new entry. The new entry gets the captured tag, counter 4 if taken or 3 if not, and useful counter 0.
- R9: On a wrong final prediction where every candidate above the provider has a nonzero useful counter, each of those counters is decremented by one and nothing is allocated.
- R10: At resolution, ghist shifts in the outcome at bit 0 and phist shifts in bit 0 of the captured lookup PC.
- R11: Resolution uses the indices, tags and provider captured at the last lookup with lkp_valid=1. A PC presented without lkp_valid does not replace the capture.
- R12: With res_valid low, res_taken has no effect on any table or history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_valid | input | 1 | Capture this lookup for the next resolution |
| lkp_pc | input | 16 | Branch address being looked up |
| res_valid | input | 1 | Resolution strobe for the captured branch |
| res_taken | input | 1 | Actual outcome of the captured branch |
| pred_taken | output | 1 | Predicted direction for lkp_pc |
| pred_src | output | 2 | Provider table number, 0 for the base table |
| pred_alt | output | 2 | Alternate table number, 0 for the base table |
| pred_alt_used | output | 1 | Alternate's prediction was chosen over a newly allocated provider |

## Verification
The assertions assume that res_valid and res_taken are driven to known values from reset onward. They also assume that each resolution belongs to the most recently captured lookup, so that allocation and useful-bit training act on consistent indices. The stimulus follows a strict pattern: one strobed lookup, then one resolution in the following cycle. Extra non-strobed PCs and res_taken toggles are inserted only in gaps where res_valid is low. A bench-side model built from the stated hashes and update rules predicts every output, so repetitive patterns, single-address bias and a many-address random mix can all be compared cycle for cycle.

// File: rtl/geo_pred_pkg.sv
package geo_pred_pkg;

  localparam int CTR_W = 3;
  localparam int USE_W = 2;

  // XOR-fold the lowest len bits of h into a w-bit value (w <= 16)
  function automatic logic [15:0] fold_hist(input logic [63:0] h,
                                            input int unsigned len,
                                            input int unsigned w);
    logic [15:0] r;
    r = '0;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < len) r[i % w] = r[i % w] ^ h[i];
    end
    return r;
  endfunction

  function automatic logic [CTR_W-1:0] sat_dir(input logic [CTR_W-1:0] c,
                                               input logic up);
    logic [CTR_W-1:0] r;
    if (up) r = (c == '1) ? c : c + 1'b1;
    else    r = (c == '0) ? c : c - 1'b1;
    return r;
  endfunction

  function automatic logic [1:0] sat2(input logic [1:0] c, input logic up);
    logic [1:0] r;
    if (up) r = (c == 2'd3) ? c : c + 2'd1;
    else    r = (c == 2'd0) ? c : c - 2'd1;
    return r;
  endfunction

endpackage

// File: rtl/geo_hist_regs.sv
module geo_hist_regs #(
  parameter int GW = 44,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          g_bit,
  input  logic          p_bit,
  output logic [GW-1:0] ghist,
  output logic [PW-1:0] phist
);

  logic [GW-1:0] g_d;
  logic [PW-1:0] p_d;

  always_comb begin
    g_d = {ghist[GW-2:0], g_bit};
    p_d = {phist[PW-2:0], p_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ghist <= '0;
      phist <= '0;
    end else if (shift_en) begin
      ghist <= g_d;
      phist <= p_d;
    end
  end

endmodule

// File: rtl/geo_base_table.sv
module geo_base_table #(
  parameter int IDX_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_cnt,
  input  logic [IDX_W-1:0] up_idx,
  output logic [1:0]       up_cnt,
  input  logic             wr_en,
  input  logic [1:0]       wr_cnt
);

  logic [DEPTH-1:0][1:0] cnt_q;

  assign rd_cnt = cnt_q[rd_idx];
  assign up_cnt = cnt_q[up_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= {DEPTH{2'b01}};
    end else if (wr_en) begin
      cnt_q[up_idx] <= wr_cnt;
    end
  end

endmodule

// File: rtl/geo_tag_bank.sv
module geo_tag_bank
  import geo_pred_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  // lookup port
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [CTR_W-1:0] lk_ctr,
  output logic [USE_W-1:0] lk_use,
  // update port
  input  logic [IDX_W-1:0] up_idx,
  output logic [CTR_W-1:0] up_ctr,
  output logic [USE_W-1:0] up_use,
  input  logic             w_ctr_en,
  input  logic [CTR_W-1:0] w_ctr,
  input  logic             w_use_en,
  input  logic [USE_W-1:0] w_use,
  input  logic             w_fill,
  input  logic [TAG_W-1:0] w_tag
);

  logic [DEPTH-1:0]            filled_q;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q;
  logic [DEPTH-1:0][CTR_W-1:0] ctr_q;
  logic [DEPTH-1:0][USE_W-1:0] use_q;

  assign lk_hit = filled_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_ctr = ctr_q[lk_idx];
  assign lk_use = use_q[lk_idx];
  assign up_ctr = ctr_q[up_idx];
  assign up_use = use_q[up_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled_q <= '0;
      tag_q    <= '0;
    end else if (w_fill) begin
      filled_q[up_idx] <= 1'b1;
      tag_q[up_idx]    <= w_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q <= '0;
    end else if (w_ctr_en) begin
      ctr_q[up_idx] <= w_ctr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_q <= '0;
    end else if (w_use_en) begin
      use_q[up_idx] <= w_use;
    end
  end

endmodule

// File: rtl/geo_dir_pred.sv
module geo_dir_pred
  import geo_pred_pkg::*;
#(
  parameter int              PC_W      = 16,
  parameter int              BIM_IDX_W = 8,
  parameter int              NT        = 3,
  parameter int              IDX_W     = 6,
  parameter int              TAG_W     = 8,
  parameter int              PATH_W    = 16,
  parameter logic [NT*8-1:0] HIST_LENS = {8'd44, 8'd15, 8'd5},
  localparam int             SRC_W     = $clog2(NT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lkp_valid,
  input  logic [PC_W-1:0]  lkp_pc,
  input  logic             res_valid,
  input  logic             res_taken,
  output logic             pred_taken,
  output logic [SRC_W-1:0] pred_src,
  output logic [SRC_W-1:0] pred_alt,
  output logic             pred_alt_used
);

  function automatic int longest_hist();
    int m;
    m = 2;
    for (int i = 0; i < NT; i++) begin
      if (int'(HIST_LENS[i*8 +: 8]) > m) m = int'(HIST_LENS[i*8 +: 8]);
    end
    return m;
  endfunction

  localparam int GHIST_W = longest_hist();

  typedef struct packed {
    logic [NT-1:0][IDX_W-1:0] idx;
    logic [NT-1:0][TAG_W-1:0] tag;
    logic [SRC_W-1:0]         prov;
    logic                     ppred;
    logic                     apred;
    logic                     pred;
    logic [BIM_IDX_W-1:0]     bidx;
    logic                     pc0;
  } cap_t;

  // history
  logic [GHIST_W-1:0] ghist;
  logic [PATH_W-1:0]  phist;
  logic [63:0]        g64;
  logic [63:0]        p64;

  assign g64 = 64'(ghist);
  assign p64 = 64'(phist);

  // lookup side
  logic [NT-1:0][IDX_W-1:0] lk_idx;
  logic [NT-1:0][TAG_W-1:0] lk_tag;
  logic [NT-1:0]            lk_hit;
  logic [NT-1:0][CTR_W-1:0] lk_ctr;
  logic [NT-1:0][USE_W-1:0] lk_use;
  logic [1:0]               base_rd;
  logic                     base_pred;

  // update side
  cap_t                     cap_d, cap_q;
  logic [NT-1:0][CTR_W-1:0] up_ctr;
  logic [NT-1:0][USE_W-1:0] up_use;
  logic [NT-1:0]            w_ctr_en;
  logic [NT-1:0][CTR_W-1:0] w_ctr;
  logic [NT-1:0]            w_use_en;
  logic [NT-1:0][USE_W-1:0] w_use;
  logic [NT-1:0]            w_alloc;
  logic [1:0]               base_up;
  logic                     base_we;
  logic [1:0]               base_w;
  logic                     mispred;
  logic                     found;

  // per-table hashing and storage
  for (genvar t = 0; t < NT; t++) begin : g_tbl
    localparam int HL = int'(HIST_LENS[t*8 +: 8]);
    localparam int PL = (HL < PATH_W) ? HL : PATH_W;

    assign lk_idx[t] = lkp_pc[IDX_W-1:0] ^ lkp_pc[2*IDX_W-1:IDX_W]
                     ^ IDX_W'(fold_hist(g64, HL, IDX_W))
                     ^ IDX_W'(fold_hist(p64, PL, IDX_W));
    assign lk_tag[t] = lkp_pc[PC_W-1 -: TAG_W]
                     ^ TAG_W'(fold_hist(g64, HL, TAG_W))
                     ^ TAG_W'(fold_hist(g64, HL, TAG_W - 1) << 1);

    geo_tag_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_idx  (lk_idx[t]),
      .lk_tag  (lk_tag[t]),
      .lk_hit  (lk_hit[t]),
      .lk_ctr  (lk_ctr[t]),
      .lk_use  (lk_use[t]),
      .up_idx  (cap_q.idx[t]),
      .up_ctr  (up_ctr[t]),
      .up_use  (up_use[t]),
      .w_ctr_en(w_ctr_en[t]),
      .w_ctr   (w_ctr[t]),
      .w_use_en(w_use_en[t]),
      .w_use   (w_use[t]),
      .w_fill  (w_alloc[t]),
      .w_tag   (cap_q.tag[t])
    );
  end

  geo_base_table #(.IDX_W(BIM_IDX_W)) u_base (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_idx(lkp_pc[BIM_IDX_W-1:0]),
    .rd_cnt(base_rd),
    .up_idx(cap_q.bidx),
    .up_cnt(base_up),
    .wr_en (base_we),
    .wr_cnt(base_w)
  );

  assign base_pred = base_rd[1];

  // provider / alternate selection
  logic [SRC_W-1:0] prov, alt;
  logic [CTR_W-1:0] p_ctr, a_ctr;
  logic [USE_W-1:0] p_use;
  logic             prov_pred, alt_pred, fresh;

  always_comb begin
    prov  = '0;
    alt   = '0;
    p_ctr = '0;
    a_ctr = '0;
    p_use = '0;
    for (int t = 0; t < NT; t++) begin
      if (lk_hit[t]) begin
        alt   = prov;
        a_ctr = p_ctr;
        prov  = SRC_W'(t + 1);
        p_ctr = lk_ctr[t];
        p_use = lk_use[t];
      end
    end
    prov_pred = p_ctr[CTR_W-1];
    alt_pred  = (alt != '0) ? a_ctr[CTR_W-1] : base_pred;
    fresh     = (prov != '0) && (p_use == '0)
             && ((p_ctr == 3'd3) || (p_ctr == 3'd4));
  end

  assign pred_src      = prov;
  assign pred_alt      = alt;
  assign pred_alt_used = fresh;
  assign pred_taken    = (prov == '0) ? base_pred : (fresh ? alt_pred : prov_pred);

  // capture register
  always_comb begin
    cap_d.idx   = lk_idx;
    cap_d.tag   = lk_tag;
    cap_d.prov  = prov;
    cap_d.ppred = prov_pred;
    cap_d.apred = alt_pred;
    cap_d.pred  = pred_taken;
    cap_d.bidx  = lkp_pc[BIM_IDX_W-1:0];
    cap_d.pc0   = lkp_pc[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (lkp_valid) begin
      cap_q <= cap_d;
    end
  end

  // resolution: training and allocation
  always_comb begin
    w_ctr_en = '0;
    w_ctr    = '0;
    w_use_en = '0;
    w_use    = '0;
    w_alloc  = '0;
    found    = 1'b0;
    mispred  = cap_q.pred ^ res_taken;
    base_we  = res_valid && (cap_q.prov == '0);
    base_w   = sat2(base_up, res_taken);

    for (int t = 0; t < NT; t++) begin
      if (res_valid && (cap_q.prov == SRC_W'(t + 1))) begin
        w_ctr_en[t] = 1'b1;
        w_ctr[t]    = sat_dir(up_ctr[t], res_taken);
        if (cap_q.ppred != cap_q.apred) begin
          w_use_en[t] = 1'b1;
          w_use[t]    = sat2(up_use[t], cap_q.ppred == res_taken);
        end
      end
    end

    if (res_valid && mispred) begin
      for (int t = 0; t < NT; t++) begin
        if ((SRC_W'(t + 1) > cap_q.prov) && !found && (up_use[t] == '0)) begin
          found       = 1'b1;
          w_alloc[t]  = 1'b1;
          w_ctr_en[t] = 1'b1;
          w_ctr[t]    = res_taken ? 3'd4 : 3'd3;
          w_use_en[t] = 1'b1;
          w_use[t]    = '0;
        end
      end
      if (!found) begin
        for (int t = 0; t < NT; t++) begin
          if (SRC_W'(t + 1) > cap_q.prov) begin
            w_use_en[t] = 1'b1;
            w_use[t]    = up_use[t] - 2'd1;
          end
        end
      end
    end
  end

  geo_hist_regs #(.GW(GHIST_W), .PW(PATH_W)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(res_valid),
    .g_bit   (res_taken),
    .p_bit   (cap_q.pc0),
    .ghist   (ghist),
    .phist   (phist)
  );

endmodule

// File: rtl/geo_dir_pred_chk.sv
module geo_dir_pred_chk #(
  parameter int NT    = 3,
  parameter int SRC_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic             res_taken,
  input logic             pred_taken,
  input logic [SRC_W-1:0] pred_src,
  input logic [SRC_W-1:0] pred_alt,
  input logic             pred_alt_used,
  input logic             base_pred,
  input logic             ghist_lsb,
  input logic [NT-1:0]    alloc_vec
);

  a_r4_alt_below_provider: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_src != '0) |-> (pred_alt < pred_src));

  a_r4_no_alt_without_provider: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_src == '0) |-> (pred_alt == '0));

  a_r5_alt_needs_provider: assert property (@(posedge clk) disable iff (!rst_n)
    pred_alt_used |-> (pred_src != '0));

  a_r2_base_serves_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_src == '0) |-> (pred_taken == base_pred));

  a_r10_outcome_shifted: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (ghist_lsb == $past(res_taken)));

  a_r12_history_held: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(ghist_lsb));

  a_r8_single_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec));

  a_r8_alloc_at_resolve: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vec != '0) |-> res_valid);

endmodule

bind geo_dir_pred geo_dir_pred_chk #(.NT(NT), .SRC_W(SRC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .res_valid    (res_valid),
  .res_taken    (res_taken),
  .pred_taken   (pred_taken),
  .pred_src     (pred_src),
  .pred_alt     (pred_alt),
  .pred_alt_used(pred_alt_used),
  .base_pred    (base_pred),
  .ghist_lsb    (ghist[0]),
  .alloc_vec    (w_alloc)
);

// File: tb/tb_geo_dir_pred.sv
module tb_geo_dir_pred;

  logic        clk;
  logic        rst_n;
  logic        lkp_valid;
  logic [15:0] lkp_pc;
  logic        res_valid;
  logic        res_taken;
  logic        pred_taken;
  logic [1:0]  pred_src;
  logic [1:0]  pred_alt;
  logic        pred_alt_used;

  int n_chk;
  int n_fail;
  bit done;

  geo_dir_pred dut (
    .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
    .res_valid(res_valid), .res_taken(res_taken), .pred_taken(pred_taken),
    .pred_src(pred_src), .pred_alt(pred_alt), .pred_alt_used(pred_alt_used)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- reference model built from R1..R12 ----------------
  int        LEN [3] = '{5, 15, 44};
  bit        m_fill [3][64];
  bit [7:0]  m_tag  [3][64];
  bit [2:0]  m_ctr  [3][64];
  bit [1:0]  m_use  [3][64];
  bit [1:0]  m_bim  [256];
  bit [63:0] m_g;
  bit [15:0] m_p;

  bit [5:0]  cp_idx [3];
  bit [7:0]  cp_tag [3];
  int        cp_prov;
  bit        cp_ppred, cp_apred, cp_pred, cp_pc0;
  bit [7:0]  cp_bidx;

  bit        e_pred, e_used;
  int        e_src, e_alt;
  bit        seen_tagged, seen_alt_used;

  function automatic bit [15:0] hfold(bit [63:0] h, int len, int w);
    bit [15:0] r = '0;
    for (int i = 0; i < 64; i++) if (i < len) r[i % w] ^= h[i];
    return r;
  endfunction

  function automatic bit [1:0] up2(bit [1:0] c, bit up);
    if (up) return (c == 3) ? c : c + 2'd1;
    return (c == 0) ? c : c - 2'd1;
  endfunction

  function automatic bit [2:0] up3(bit [2:0] c, bit up);
    if (up) return (c == 7) ? c : c + 3'd1;
    return (c == 0) ? c : c - 3'd1;
  endfunction

  task automatic m_reset();
    for (int t = 0; t < 3; t++)
      for (int i = 0; i < 64; i++) begin
        m_fill[t][i] = 0; m_tag[t][i] = 0; m_ctr[t][i] = 0; m_use[t][i] = 0;
      end
    for (int i = 0; i < 256; i++) m_bim[i] = 2'd1;
    m_g = '0; m_p = '0;
    for (int t = 0; t < 3; t++) begin cp_idx[t] = 0; cp_tag[t] = 0; end
    cp_prov = 0; cp_ppred = 0; cp_apred = 0; cp_pred = 0; cp_pc0 = 0; cp_bidx = 0;
  endtask

  // R3/R4/R5 lookup; capture when cap=1 (R11)
  task automatic m_lookup(bit [15:0] pc, bit cap);
    bit [5:0] ix [3];
    bit [7:0] tg [3];
    bit [15:0] sh;
    int pl;
    bit pp, ap, bp, fr;
    int pv = 0, al = 0;
    for (int t = 0; t < 3; t++) begin
      pl = (LEN[t] < 16) ? LEN[t] : 16;
      ix[t] = pc[5:0] ^ pc[11:6] ^ hfold(m_g, LEN[t], 6)[5:0] ^ hfold({48'd0, m_p}, pl, 6)[5:0];
      sh = hfold(m_g, LEN[t], 7) << 1;
      tg[t] = pc[15:8] ^ hfold(m_g, LEN[t], 8)[7:0] ^ sh[7:0];
      if (m_fill[t][ix[t]] && m_tag[t][ix[t]] == tg[t]) begin al = pv; pv = t + 1; end
    end
    bp = m_bim[pc[7:0]][1];
    pp = (pv != 0) ? m_ctr[pv-1][ix[pv-1]][2] : 1'b0;
    ap = (al != 0) ? m_ctr[al-1][ix[al-1]][2] : bp;
    fr = (pv != 0) && (m_use[pv-1][ix[pv-1]] == 0) &&
         (m_ctr[pv-1][ix[pv-1]] == 3 || m_ctr[pv-1][ix[pv-1]] == 4);
    e_src = pv; e_alt = al; e_used = fr;
    e_pred = (pv == 0) ? bp : (fr ? ap : pp);
    if (cap) begin
      for (int t = 0; t < 3; t++) begin cp_idx[t] = ix[t]; cp_tag[t] = tg[t]; end
      cp_prov = pv; cp_ppred = pp; cp_apred = ap; cp_pred = e_pred;
      cp_bidx = pc[7:0]; cp_pc0 = pc[0];
    end
  endtask

  // R2/R6/R7/R8/R9/R10 resolution
  task automatic m_resolve(bit tk);
    bit found = 0;
    if (cp_prov == 0) m_bim[cp_bidx] = up2(m_bim[cp_bidx], tk);
    else begin
      int p = cp_prov - 1;
      m_ctr[p][cp_idx[p]] = up3(m_ctr[p][cp_idx[p]], tk);
      if (cp_ppred != cp_apred) m_use[p][cp_idx[p]] = up2(m_use[p][cp_idx[p]], cp_ppred == tk);
    end
    if (cp_pred != tk) begin
      for (int t = cp_prov; t < 3; t++)
        if (!found && m_use[t][cp_idx[t]] == 0) begin
          found = 1;
          m_fill[t][cp_idx[t]] = 1; m_tag[t][cp_idx[t]] = cp_tag[t];
          m_ctr[t][cp_idx[t]] = tk ? 3'd4 : 3'd3; m_use[t][cp_idx[t]] = 0;
        end
      if (!found)
        for (int t = cp_prov; t < 3; t++) m_use[t][cp_idx[t]] = m_use[t][cp_idx[t]] - 2'd1;
    end
    m_g = {m_g[62:0], tk};
    m_p = {m_p[14:0], cp_pc0};
  endtask

  // ---------------- checking helpers ----------------
  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_outputs(string req);
    int a = {pred_taken, pred_src, pred_alt, pred_alt_used};
    int e = {e_pred, e_src[1:0], e_alt[1:0], e_used};
    check(a == e, req, "{pred,src,alt,alt_used}", a, e);
    if (pred_src != 0) seen_tagged = 1;
    if (pred_alt_used) seen_alt_used = 1;
  endtask

  // one strobed lookup followed by its resolution
  task automatic branch(bit [15:0] pc, bit tk, string req);
    @(negedge clk);
    lkp_valid = 1; lkp_pc = pc; res_valid = 0;
    #1;
    m_lookup(pc, 1);
    cmp_outputs(req);
    @(negedge clk);
    lkp_valid = 0; res_valid = 1; res_taken = tk;
    m_resolve(tk);
    @(negedge clk);
    res_valid = 0;
  endtask

  task automatic peek(bit [15:0] pc, string req);
    @(negedge clk);
    lkp_valid = 0; lkp_pc = pc;
    #1;
    m_lookup(pc, 0);
    cmp_outputs(req);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    bit [15:0] pcs [4] = '{16'h0000, 16'h1234, 16'hbeef, 16'hffff};
    rst_n = 0; lkp_valid = 0; lkp_pc = 0; res_valid = 0; res_taken = 0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    foreach (pcs[i]) begin
      @(negedge clk);
      lkp_pc = pcs[i];
      #1;
      // R1: empty tables, weak not-taken base
      check(pred_taken == 0 && pred_src == 0 && pred_alt == 0, "R1", "reset prediction",
            {pred_taken, pred_src, pred_alt}, 0);
    end
  endtask

  task automatic t_bias();
    // R2/R6: one address always taken trains toward taken
    for (int i = 0; i < 60; i++) branch(16'h0a40, 1'b1, "R2");
    peek(16'h0a40, "R2");
    check(pred_taken == 1, "R2", "biased address predicts taken", pred_taken, 1);
  endtask

  task automatic t_loop();
    // R3/R4/R5/R7/R8: period-4 pattern needs the tagged tables
    seen_tagged = 0; seen_alt_used = 0;
    for (int i = 0; i < 150; i++)
      for (int k = 0; k < 4; k++) branch(16'h5a3c, (k != 3), "R4");
    check(seen_tagged, "R4", "tagged provider observed", seen_tagged, 1);
    check(seen_alt_used, "R5", "fresh entry deferred to alternate", seen_alt_used, 1);
  endtask

  task automatic t_hold();
    // R11: an unstrobed PC between lookup and resolution is ignored
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      lkp_valid = 1; lkp_pc = 16'h3c00 + 16'(i); res_valid = 0;
      #1; m_lookup(lkp_pc, 1); cmp_outputs("R11");
      @(negedge clk);
      lkp_valid = 0; lkp_pc = 16'hc3ff - 16'(i);
      @(negedge clk);
      res_valid = 1; res_taken = i[0];
      m_resolve(i[0]);
      @(negedge clk);
      res_valid = 0;
      peek(16'h3c00 + 16'(i), "R11");
    end
  endtask

  task automatic t_no_resolve();
    // R12: res_taken toggling with res_valid low changes nothing
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      res_valid = 0; res_taken = i[0];
    end
    peek(16'h5a3c, "R12");
    peek(16'h0a40, "R12");
    peek(16'h3c05, "R12");
  endtask

  task automatic t_mix();
    // R6/R7/R8/R9/R10: many addresses, biased outcomes, table conflicts
    for (int i = 0; i < 700; i++) begin
      bit [15:0] pc = 16'($urandom_range(0, 23)) * 16'h0b35;
      bit tk = ($urandom_range(0, 9) < (pc[3] ? 8 : 2));
      branch(pc, tk, (i % 2) ? "R9" : "R10");
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    t_reset();
    t_bias();
    t_loop();
    t_hold();
    t_no_resolve();
    t_mix();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule